// File: doc/BRIEF.md
# Self-Timed Word Programming Engine

This block takes a word write that a serial command front end has already decoded, and commits it to a word array over a self-timed programming interval. The interval length is counted in system clocks. While a write is in flight the block holds a ready flag low and takes no other command. After the interval the new 16-bit word fully replaces the old one, which stands in for an automatic erase-before-write.

Writes only go through while a volatile programming-enable latch is set. The front end sets this latch with an unlock pulse and clears it with a lock pulse, and reset leaves it clear. A write-guard input can stop a cycle in progress. If the guard stops the cycle in its early settle window, the word is left untouched. If it stops the cycle later, the word is left holding a fixed corrupt pattern.

After a write command has been issued, the host can read the ready/busy state on the serial data line. It does this by lowering the active-low select while the serial clock is low. The status is driven until the select rises again.

Top module: `prog_cycle_engine`

## Requirements
- R1: After reset the enable latch is clear, `ready` is 1 and `st_oe` is 0. A write request issued before any unlock is refused, and `ready` stays 1.
- R2: `req_unlock` sets the enable latch and `req_lock` clears it. If both arrive in the same cycle, the lock wins. The latch holds its value until the next lock or reset.
- R3: An accepted write drives `ready` to 0 in the cycle after the request. `ready` stays 0 for exactly PROG_CYCLES cycles. It then returns to 1, and from that cycle the addressed word equals the requested data.
- R4: While `ready` is 0, write, unlock and lock requests are ignored. The latch value and the word being programmed are unaffected.
- R5: If `wguard` is 1 at a clock edge where fewer than SETTLE_CYCLES busy cycles have elapsed, the cycle ends. `ready` is 1 in the next cycle and the target word keeps its old value.
- R6: If `wguard` is 1 at a clock edge where at least SETTLE_CYCLES busy cycles have elapsed, the cycle ends. `ready` is 1 in the next cycle and the target word holds CORRUPT_WORD (default 16'hBAD5).
- R7: `wguard` has no effect on unlock or lock requests. A write request while `wguard` is 1 is refused.
- R8: After a write has been issued, a falling edge of `sel_n` seen while `ser_clk` is 0 sets `st_oe` to 1 from the next cycle on. While `st_oe` is 1, `st_bit` equals `ready`. `sel_n` at 1 clears `st_oe` in the next cycle.
- R9: A falling edge of `sel_n` while `ser_clk` is 1 does not set `st_oe`. Once `sel_n` has been 1 while `ready` is 1, the pending write is released, and later select edges do not set `st_oe`.
- R10: `rd_data` combinationally returns the word stored at `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_write | input | 1 | One-cycle write request from the command front end |
| req_addr | input | clog2(DEPTH) | Word address of the write |
| req_data | input | 16 | Word to program |
| req_unlock | input | 1 | Set the programming-enable latch |
| req_lock | input | 1 | Clear the programming-enable latch |
| wguard | input | 1 | Write guard; high stops a cycle in progress |
| sel_n | input | 1 | Active-low device select from the host |
| ser_clk | input | 1 | Serial clock level, sampled in the system clock domain |
| rd_addr | input | clog2(DEPTH) | Read address for the front end |
| rd_data | output | 16 | Stored word at rd_addr |
| ready | output | 1 | 1 = idle and accepting commands, 0 = programming |
| st_oe | output | 1 | Drive enable for the status mirror on the data line |
| st_bit | output | 1 | Status level on the data line (ready when enabled) |

## Verification
The hardest case to reach is a guard abort that lands on a specific side of the settle boundary. The edge has to be placed relative to the busy-cycle count, which the ports do not expose. The bench counts edges from the request pulse and raises the guard once at busy count 2 and once at busy count 10, with a short interval and settle window set by parameter. It then reads the target word back through the read port. The status mirror needs a similar ordering: a write in flight, then a select edge with the serial clock low, then a release. After the release, a second select shows the mirror stays off.

// File: rtl/prog_pkg.sv
package prog_pkg;
    localparam int WORD_W = 16;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_PROG = 1'b1
    } phase_t;
endpackage

// File: rtl/prog_word_array.sv
module prog_word_array #(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WORD_W-1:0]        rdata
);
    logic [WORD_W-1:0] cells_q [DEPTH];

    // whole-word replacement models erase-then-program in one step
    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer #(
    parameter int PROG_CYCLES   = 500000,
    parameter int SETTLE_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last,
    output logic safe
);
    localparam int CW = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (run && !last) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end else begin
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign last = (tmr_q.cnt == CW'(PROG_CYCLES - 1));
    assign safe = (tmr_q.cnt <  CW'(SETTLE_CYCLES));

    // interval always starts from zero
    assert_fresh_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (tmr_q.cnt == '0));

    // count never reaches the interval length
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt < CW'(PROG_CYCLES));
endmodule

// File: rtl/prog_status_mirror.sv
module prog_status_mirror (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic ser_clk,
    input  logic pending,
    input  logic ready,
    output logic st_oe,
    output logic st_bit
);
    typedef struct packed {
        logic sel_prev;
        logic oe;
    } mir_t;

    mir_t mir_d, mir_q;

    always_comb begin
        mir_d          = mir_q;
        mir_d.sel_prev = sel_n;
        if (sel_n) begin
            mir_d.oe = 1'b0;
        end else if (mir_q.sel_prev && !ser_clk && pending) begin
            mir_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mir_q <= '{sel_prev: 1'b1, oe: 1'b0};
        end else begin
            mir_q <= mir_d;
        end
    end

    assign st_oe  = mir_q.oe;
    assign st_bit = mir_q.oe & ready;

    assert_release_on_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !st_oe);

    assert_no_mirror_sk_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_oe && ser_clk) |=> !st_oe);
endmodule

// File: rtl/prog_cycle_engine.sv
module prog_cycle_engine
    import prog_pkg::*;
#(
    parameter int               DEPTH         = 512,
    parameter int               PROG_CYCLES   = 500000,
    parameter int               SETTLE_CYCLES = 50000,
    parameter logic [WORD_W-1:0] CORRUPT_WORD = 16'hBAD5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_write,
    input  logic [$clog2(DEPTH)-1:0] req_addr,
    input  logic [WORD_W-1:0]        req_data,
    input  logic                     req_unlock,
    input  logic                     req_lock,
    input  logic                     wguard,
    input  logic                     sel_n,
    input  logic                     ser_clk,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     ready,
    output logic                     st_oe,
    output logic                     st_bit
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        phase_t            phase;
        logic              unlocked;
        logic              pending;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] data;
    } eng_t;

    eng_t              eng_d, eng_q;
    logic              start;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata;
    logic              tmr_last;
    logic              tmr_safe;
    logic              busy;

    assign busy = (eng_q.phase == PH_PROG);

    prog_interval_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .last (tmr_last),
        .safe (tmr_safe)
    );

    always_comb begin
        eng_d     = eng_q;
        start     = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = eng_q.data;
        unique case (eng_q.phase)
            PH_IDLE: begin
                start = req_write && eng_q.unlocked && !wguard;
                if (req_lock) begin
                    eng_d.unlocked = 1'b0;
                end else if (req_unlock) begin
                    eng_d.unlocked = 1'b1;
                end
                if (start) begin
                    eng_d.phase   = PH_PROG;
                    eng_d.addr    = req_addr;
                    eng_d.data    = req_data;
                    eng_d.pending = 1'b1;
                end else if (sel_n) begin
                    eng_d.pending = 1'b0;
                end
            end
            PH_PROG: begin
                if (wguard) begin
                    eng_d.phase = PH_IDLE;
                    if (!tmr_safe) begin
                        mem_we    = 1'b1;
                        mem_wdata = CORRUPT_WORD;
                    end
                end else if (tmr_last) begin
                    eng_d.phase = PH_IDLE;
                    mem_we      = 1'b1;
                    mem_wdata   = eng_q.data;
                end
            end
            default: eng_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{phase: PH_IDLE, unlocked: 1'b0, pending: 1'b0,
                       addr: '0, data: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    prog_word_array #(
        .DEPTH (DEPTH),
        .WORD_W(WORD_W)
    ) u_array (
        .clk  (clk),
        .we   (mem_we),
        .waddr(eng_q.addr),
        .wdata(mem_wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    prog_status_mirror u_mirror (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .ser_clk(ser_clk),
        .pending(eng_q.pending),
        .ready  (ready),
        .st_oe  (st_oe),
        .st_bit (st_bit)
    );

    assign ready = !busy;

    assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);

    assert_latch_frozen_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (eng_q.unlocked == $past(eng_q.unlocked)));

    assert_guard_ends_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wguard) |=> ready);

    assert_unlock_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.unlocked) |-> $past(req_unlock && !req_lock));

    assert_no_write_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !eng_q.unlocked) |=> ready);
endmodule

// File: tb/prog_cycle_engine_test.sv
module prog_cycle_engine_test;
    localparam int DEPTH  = 64;
    localparam int PROG   = 20;
    localparam int SETTLE = 6;
    localparam logic [15:0] BADW = 16'hBAD5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_data = '0;
    logic        req_unlock = 1'b0;
    logic        req_lock = 1'b0;
    logic        wguard = 1'b0;
    logic        sel_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ready, st_oe, st_bit;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    prog_cycle_engine #(
        .DEPTH(DEPTH), .PROG_CYCLES(PROG), .SETTLE_CYCLES(SETTLE), .CORRUPT_WORD(BADW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_addr(req_addr),
        .req_data(req_data), .req_unlock(req_unlock), .req_lock(req_lock),
        .wguard(wguard), .sel_n(sel_n), .ser_clk(ser_clk), .rd_addr(rd_addr),
        .rd_data(rd_data), .ready(ready), .st_oe(st_oe), .st_bit(st_bit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // behavioural reference model
    bit          m_busy, m_en, m_pend, m_oe, m_selq;
    int          m_cnt;
    int          m_a;
    logic [15:0] m_dat;
    logic [15:0] mmem [int];

    always @(posedge clk) begin
        bit o_busy, o_en, o_pend, o_selq;
        if (!rst_n) begin
            m_busy = 0; m_en = 0; m_pend = 0; m_oe = 0; m_selq = 1; m_cnt = 0;
        end else begin
            o_busy = m_busy; o_en = m_en; o_pend = m_pend; o_selq = m_selq;
            if (sel_n) m_oe = 0;
            else if (o_selq && !ser_clk && o_pend) m_oe = 1;
            m_selq = sel_n;
            if (!o_busy) begin
                if (req_write && o_en && !wguard) begin
                    m_busy = 1; m_cnt = 0; m_a = int'(req_addr); m_dat = req_data; m_pend = 1;
                end else if (sel_n) begin
                    m_pend = 0;
                end
                if (req_lock) m_en = 0;
                else if (req_unlock) m_en = 1;
            end else begin
                if (wguard) begin
                    m_busy = 0;
                    if (m_cnt >= SETTLE) mmem[m_a] = BADW;
                end else if (m_cnt == PROG - 1) begin
                    mmem[m_a] = m_dat;
                    m_busy = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    // per-cycle comparison, well away from the edge
    always @(posedge clk) begin
        #15;
        if (rst_n && !finished) begin
            chk(ready == !m_busy, "R3 ready vs model", int'(ready), int'(!m_busy));
            chk(st_oe == m_oe, "R8 st_oe vs model", int'(st_oe), int'(m_oe));
            chk(st_bit == (m_oe && !m_busy), "R8 st_bit vs model", int'(st_bit),
                int'(m_oe && !m_busy));
            if (mmem.exists(int'(rd_addr)))
                chk(rd_data == mmem[int'(rd_addr)], "R10 rd_data vs model",
                    int'(rd_data), int'(mmem[int'(rd_addr)]));
        end
    end

    task automatic wr_pulse(input logic [5:0] a, input logic [15:0] d);
        req_write = 1; req_addr = a; req_data = d;
        step(1);
        req_write = 0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [15:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(rd_data == exp, tag, int'(rd_data), int'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        chk(ready == 1, "R1 ready after reset", int'(ready), 1);
        chk(st_oe == 0, "R1 st_oe after reset", int'(st_oe), 0);

        wr_pulse(6'd5, 16'h1111);
        chk(ready == 1, "R1 write refused while locked", int'(ready), 1);

        req_unlock = 1; req_lock = 1; step(1); req_unlock = 0; req_lock = 0;
        wr_pulse(6'd5, 16'h1111);
        chk(ready == 1, "R2 lock wins over unlock", int'(ready), 1);

        req_unlock = 1; step(1); req_unlock = 0;
        wr_pulse(6'd5, 16'h1234);
        chk(ready == 0, "R3 busy after request", int'(ready), 0);
        req_lock = 1; req_write = 1; req_addr = 6'd5; req_data = 16'h0000;
        step(1);
        req_lock = 0; req_write = 0;
        step(PROG - 2);
        chk(ready == 0, "R3 busy through last cycle", int'(ready), 0);
        step(1);
        chk(ready == 1, "R3 ready after interval", int'(ready), 1);
        rd_chk(6'd5, 16'h1234, "R3 word committed, R4 busy write ignored");

        wr_pulse(6'd6, 16'h00F0);
        chk(ready == 0, "R4 latch kept across busy lock", int'(ready), 0);
        step(PROG);
        rd_chk(6'd6, 16'h00F0, "R10 read second word");

        wr_pulse(6'd6, 16'hFFFF);
        step(2);
        wguard = 1; step(1); wguard = 0;
        chk(ready == 1, "R5 early abort ready", int'(ready), 1);
        rd_chk(6'd6, 16'h00F0, "R5 word unchanged");

        wr_pulse(6'd7, 16'h1357);
        step(10);
        wguard = 1; step(1); wguard = 0;
        chk(ready == 1, "R6 late abort ready", int'(ready), 1);
        rd_chk(6'd7, BADW, "R6 corrupt pattern");

        wguard = 1; req_lock = 1; step(1); req_lock = 0; wguard = 0;
        wr_pulse(6'd8, 16'h4444);
        chk(ready == 1, "R7 lock honoured under guard", int'(ready), 1);
        wguard = 1; req_unlock = 1; step(1); req_unlock = 0; wguard = 0;
        wr_pulse(6'd8, 16'h4444);
        chk(ready == 0, "R7 unlock honoured under guard", int'(ready), 0);
        step(PROG);
        wguard = 1;
        wr_pulse(6'd8, 16'h5555);
        wguard = 0;
        chk(ready == 1, "R7 write refused under guard", int'(ready), 1);
        rd_chk(6'd8, 16'h4444, "R7 word kept");

        wr_pulse(6'd9, 16'h2468);
        sel_n = 0; ser_clk = 0; step(1);
        chk(st_oe == 1, "R8 mirror enabled", int'(st_oe), 1);
        chk(st_bit == 0, "R8 mirror shows busy", int'(st_bit), 0);
        step(PROG);
        chk(st_bit == 1, "R8 mirror shows ready", int'(st_bit), 1);
        sel_n = 1; step(1);
        chk(st_oe == 0, "R8 mirror off on deselect", int'(st_oe), 0);
        sel_n = 0; step(1);
        chk(st_oe == 0, "R9 no mirror after release", int'(st_oe), 0);

        sel_n = 1; step(1);
        wr_pulse(6'd10, 16'h0A0A);
        sel_n = 0; ser_clk = 1; step(1);
        chk(st_oe == 0, "R9 no mirror with ser_clk high", int'(st_oe), 0);
        sel_n = 1; ser_clk = 0;
        step(PROG);
        rd_chk(6'd10, 16'h0A0A, "R10 read after mirror test");

        step(3);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule